// File: doc/BRIEF.md
# Descriptor Word Load/Store Engine

This engine carries out the two single-word descriptor commands of a DMA command sequencer. One of them reads a few bytes from system memory into the 32-bit parameter word of the active descriptor. The other writes bytes taken from that word out to memory. The sequencer pulses `start` and presents four things: the direction, the descriptor's key field, its request count and its data address. The engine then reduces the count to a byte size of 1, 2 or 4, and aligns the address to that size. It runs one memory access over a request/acknowledge port with per-lane byte enables, and answers with a one-cycle `done` or `kill`.

The sequencer keeps everything around the access: descriptor writeback, wait and interrupt evaluation, and pointer advance. Branch bits of these commands are never looked at because they never reach the engine. Memory data is little-endian by lane: the byte at address `a` travels on lane `a[1:0]` of the 32-bit data buses.

Top module: `dma_word_mover`

## Requirements
- R1: After reset `busy`, `mem_req`, `done` and `kill` are all 0.
- R2: The access size uses only bits 2:0 of `req_cnt`. Bit 2 set gives 4 bytes. Otherwise bit 1 set gives 2 bytes. Otherwise the size is 1 byte. Bits above bit 2 have no effect.
- R3: `mem_addr` is `addr_in` with bits 1:0 cleared for a 4-byte access, with bit 0 cleared for a 2-byte access, and unchanged for a 1-byte access.
- R4: `mem_be` carries 1, 2 or 4 ones for sizes 1, 2 and 4, shifted left by `mem_addr[1:0]`.
- R5: Key values 0 to 4 are treated as key 6 (system memory), and key 6 is accepted. An accepted start raises `mem_req` in the cycle after the start edge.
- R6: Keys 5 and 7 are rejected. `kill` is high for exactly the one cycle after the start edge, and no memory request is issued.
- R7: For a load, the fetched value `v` is `mem_rdata` shifted right by 8 times `mem_addr[1:0]`. `dep_out` becomes `v` for size 4. For size 2 it becomes `{v[15:0], dep_in[15:0]}`. For size 1 it becomes `{v[7:0], dep_in[23:0]}`.
- R8: For a store, `mem_we` is 1 and `mem_wdata` is `(dep_in >> s) << (8*mem_addr[1:0])`, truncated to 32 bits. Here `s` is 0, 16 or 24 for sizes 4, 2 and 1. For a load, `mem_we` is 0.
- R9: `mem_req`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold steady until a cycle with `mem_ack` high. `done` is high for exactly the following cycle, and `dep_out` is valid while `done` is high.
- R10: A `start` pulse while `busy` is 1 is ignored, and the transfer in flight completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| is_store | input | 1 | 1 = store word, 0 = load word |
| key | input | KEY_W | Descriptor key field |
| req_cnt | input | CNT_W | Descriptor request count |
| addr_in | input | ADDR_W | Descriptor data address |
| dep_in | input | 32 | Descriptor parameter word |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| kill | output | 1 | One-cycle pulse: command rejected |
| dep_out | output | 32 | Updated parameter word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Store data, lane placed |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data, lane placed |

## Verification
The bench runs every key value and every low pattern of the request count, with random upper bits. It covers all four address offsets in both directions and acknowledge delays of zero to two cycles. Several faults would show up here:
- A size decode that checks bit 1 before bit 2 turns counts 6 and 7 into 2-byte accesses, which shows in the enables.
- Forgetting to align would light enable lanes beyond lane 3, or put the wrong lane into `dep_out`.
- Merging a short load into the low end, or shifting the store word the wrong way, corrupts the kept bytes.
- Treating key 5 as memory issues a request where a kill is expected.

Extra start pulses during the acknowledge wait check that a busy engine does not re-latch its operands.

// File: rtl/dma_word_mover.sv
module dma_word_mover #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  parameter int KEY_W   = 3,
  parameter int SYS_KEY = 6,
  parameter int DEV_KEY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic [KEY_W-1:0]  key,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [31:0]       dep_in,
  output logic              busy,
  output logic              done,
  output logic              kill,
  output logic [31:0]       dep_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE, S_KILL} st_t;
  st_t state;

  logic [1:0]        sz_d, sz_q;
  logic [ADDR_W-1:0] addr_al;
  logic [3:0]        mask_d, be_d;
  logic [KEY_W-1:0]  key_eff;
  logic              key_ok, accept;
  logic [31:0]       st_val, wdata_d, dep_q, rx;

  assign accept  = start && (state == S_IDLE);
  assign sz_d    = req_cnt[2] ? 2'd2 : (req_cnt[1] ? 2'd1 : 2'd0);
  assign key_eff = (key < KEY_W'(DEV_KEY)) ? KEY_W'(SYS_KEY) : key;
  assign key_ok  = (key_eff == KEY_W'(SYS_KEY));

  always_comb begin
    addr_al = addr_in;
    mask_d  = 4'b0001;
    st_val  = dep_in >> 24;
    case (sz_d)
      2'd2: begin addr_al[1:0] = 2'b00; mask_d = 4'b1111; st_val = dep_in; end
      2'd1: begin addr_al[0] = 1'b0; mask_d = 4'b0011; st_val = dep_in >> 16; end
      default: ;
    endcase
  end

  assign be_d    = 4'(mask_d << addr_al[1:0]);
  assign wdata_d = st_val << {addr_al[1:0], 3'b000};
  assign rx      = mem_rdata >> {mem_addr[1:0], 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sz_q      <= 2'd0;
      mem_addr  <= '0;
      mem_be    <= 4'b0;
      mem_we    <= 1'b0;
      mem_wdata <= 32'b0;
      dep_q     <= 32'b0;
      dep_out   <= 32'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (key_ok) begin
            state     <= S_REQ;
            sz_q      <= sz_d;
            mem_addr  <= addr_al;
            mem_be    <= be_d;
            mem_we    <= is_store;
            mem_wdata <= wdata_d;
            dep_q     <= dep_in;
          end else begin
            state <= S_KILL;
          end
        end
        S_REQ: if (mem_ack) begin
          state <= S_DONE;
          if (mem_we)
            dep_out <= dep_q;
          else
            case (sz_q)
              2'd2:    dep_out <= rx;
              2'd1:    dep_out <= {rx[15:0], dep_q[15:0]};
              default: dep_out <= {rx[7:0], dep_q[23:0]};
            endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign mem_req = (state == S_REQ);
  assign done    = (state == S_DONE);
  assign kill    = (state == S_KILL);

  AST_BE_WIDTH:   assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) inside {1, 2, 4})); // R4
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $countones(mem_be) == 4) |-> (mem_addr[1:0] == 2'b00)); // R3
  AST_REQ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata))); // R9
  AST_DONE_NEXT:  assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !mem_req)); // R9
  AST_ONE_PHASE:  assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, kill, mem_req})); // R6
  AST_KILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !kill); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mem_addr)); // R10

endmodule

// File: tb/dma_word_mover_tb_top.sv
module dma_word_mover_tb_top;
  logic clk = 0, rst_n = 0;
  logic start = 0, is_store = 0;
  logic [2:0]  key = 0;
  logic [15:0] req_cnt = 0;
  logic [31:0] addr_in = 0, dep_in = 0;
  logic busy, done, kill, mem_req, mem_we, mem_ack = 0;
  logic [31:0] dep_out, mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0]  mem_be;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_word_mover dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .key(key),
    .req_cnt(req_cnt), .addr_in(addr_in), .dep_in(dep_in), .busy(busy),
    .done(done), .kill(kill), .dep_out(dep_out), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'h9E37_79B9 ^ (a * 32'h0101_0103);
  endfunction

  task automatic run_op(input bit st, input logic [2:0] k, input logic [15:0] cnt,
                        input logic [31:0] a, input logic [31:0] dep, input int lat);
    int n, lane, sh;
    logic [31:0] ea, v, ed, ew;
    logic [3:0] eb;
    bit good;
    good = (k < 5) || (k == 6);
    if (cnt[2]) n = 4; else if (cnt[1]) n = 2; else n = 1;
    ea = (n == 4) ? (a & ~32'h3) : (n == 2) ? (a & ~32'h1) : a;
    lane = int'(ea[1:0]);
    eb = 4'(((1 << n) - 1) << lane);
    sh = (n == 4) ? 0 : (n == 2) ? 16 : 24;
    ew = (dep >> sh) << (8 * lane);
    @(negedge clk);
    start = 1; is_store = st; key = k; req_cnt = cnt; addr_in = a; dep_in = dep;
    @(negedge clk);
    start = 0;
    if (!good) begin
      chk(kill == 1 && mem_req == 0, "R6 kill pulse", {30'b0, kill, mem_req}, 32'h2);
      @(negedge clk);
      chk(kill == 0 && busy == 0, "R6 kill one cycle", {30'b0, kill, busy}, 32'h0);
      return;
    end
    chk(mem_req == 1 && kill == 0, "R5 request issued", {31'b0, mem_req}, 32'h1);
    chk(mem_addr == ea, "R3 aligned address", mem_addr, ea);
    chk(mem_be == eb, "R2/R4 byte enables", {28'b0, mem_be}, {28'b0, eb});
    chk(mem_we == st, "R8 write enable", {31'b0, mem_we}, {31'b0, st});
    if (st) chk(mem_wdata == ew, "R8 store data", mem_wdata, ew);
    for (int w = 0; w < lat; w++) begin
      start = 1; addr_in = ~a; dep_in = ~dep; req_cnt = ~cnt; is_store = ~st; key = 3'd6;
      @(negedge clk);
      start = 0;
      chk(mem_req == 1 && mem_addr == ea, "R9/R10 request held", mem_addr, ea);
    end
    v = mem_word(ea);
    mem_rdata = v; mem_ack = 1;
    @(negedge clk);
    mem_ack = 0; mem_rdata = 32'hDEAD_BEEF;
    if (st) ed = dep;
    else begin
      v = v >> (8 * lane);
      if (n == 4) ed = v;
      else if (n == 2) ed = (v << 16) | (dep & 32'h0000_FFFF);
      else ed = (v << 24) | (dep & 32'h00FF_FFFF);
    end
    chk(done == 1 && mem_req == 0, "R9 done after ack", {31'b0, done}, 32'h1);
    chk(dep_out == ed, st ? "R8 word kept" : "R7 load merge", dep_out, ed);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R9 done one cycle", {30'b0, done, busy}, 32'h0);
  endtask

  initial begin
    int it;
    it = 0;
    #1;
    chk(busy == 0 && mem_req == 0 && done == 0 && kill == 0, "R1 reset state",
        {28'b0, busy, mem_req, done, kill}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(busy == 0 && mem_req == 0, "R1 idle after reset", {30'b0, busy, mem_req}, 32'h0);
    for (int st = 0; st < 2; st++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 8; c++)
          for (int lo = 0; lo < 4; lo++) begin
            it++;
            run_op(st[0], 3'(k), 16'((it * 8 * 37) | c) & 16'hFFF8 | 16'(c),
                   32'h4000_0000 | (32'(it) << 4) | 32'(lo),
                   32'h1234_5678 ^ (32'(it) * 32'h0103_0507), it % 3);
          end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule